// File: doc/BRIEF.md
# Conversion Window Watchdog with Trigger Level and Sticky Flag

This block watches the results produced by an analog-to-digital converter. For each conversion-done strobe it decides whether the channel is guarded. A channel is guarded when its bit in a guard mask is set, or when an all-channels mode is selected. For a guarded result, the block compares the value against a programmable low bound and a programmable high bound.

The block drives two indications:
- `win_level` is a level signal that reflects the window status of the most recent guarded conversion. It is meant to feed the external trigger input of a timer.
- `win_flag` is a sticky status bit. Hardware sets it and software clears it.

The two indications are independent. The level can rise and fall many times while the flag stays set because software has not yet cleared it.

The level comes from a three-state machine:
- `ST_DISARMED`: the watchdog is off or the converter is being disabled. The level is low.
- `ST_INSIDE`: armed, with the last guarded result in the window. The level is low.
- `ST_OUTSIDE`: armed, with the last guarded result out of the window. The level is high.

The transitions are:
- **disarm**: from any state to `ST_DISARMED` when the enable is low or the converter disable command is present.
- **arm**: from `ST_DISARMED` to `ST_INSIDE`, or directly to `ST_OUTSIDE` if an out-of-window guarded result arrives in that cycle.
- **trip**: from `ST_INSIDE` to `ST_OUTSIDE` on an out-of-window guarded result.
- **recover**: from `ST_OUTSIDE` to `ST_INSIDE` on an in-window guarded result.
- **hold**: otherwise the state is kept. The stop commands for regular and injected conversions take no part in any transition.

Top module: `adc_window_watch`

## Requirements
- R1: While `rst` is high at a clock edge, both `win_level` and `win_flag` are 0 after that edge.
- R2: A guarded result strictly below `thr_low` or strictly above `thr_high`, strobed while the watchdog is enabled and not being disabled, makes `win_level` 1 after the next clock edge.
- R3: A result equal to `thr_low` or equal to `thr_high` counts as inside the window. It does not set the level or the flag.
- R4: `win_level` falls only at the edge after an in-window guarded result. It stays 1 through successive out-of-window results and through cycles with no guarded result.
- R5: A conversion is guarded when `guard_all` is 1, or when `conv_chan` < N_CHAN and `guard_mask[conv_chan]` is 1. An unguarded conversion changes neither `win_level` nor `win_flag`.
- R6: With `wd_enable` at 0, `win_level` is 0 after the next edge, and no result is evaluated: the flag is not set.
- R7: `adc_disable` at 1 forces `win_level` to 0 after the next edge, even when an out-of-window guarded result arrives in that cycle. It does not change `win_flag`.
- R8: `stop_regular` and `stop_injected` have no effect on either output.
- R9: `win_flag` is set at the edge after an enabled out-of-window guarded result. It is cleared only by `flag_clear`. When a set and a clear happen in the same cycle, the set wins.
- R10: `win_flag` has no influence on `win_level`. The level can fall on an in-window result and rise again while the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_done | input | 1 | One-cycle strobe marking a finished conversion |
| conv_data | input | DATA_W | Result of the finished conversion (unsigned) |
| conv_chan | input | CHAN_W | Channel number of the finished conversion |
| guard_mask | input | N_CHAN | One bit per channel; 1 means the channel is guarded |
| guard_all | input | 1 | Guard every channel regardless of the mask |
| thr_low | input | DATA_W | Low bound of the window (inclusive) |
| thr_high | input | DATA_W | High bound of the window (inclusive) |
| wd_enable | input | 1 | Watchdog enable |
| adc_disable | input | 1 | Converter disable command |
| stop_regular | input | 1 | Stop command for regular conversions |
| stop_injected | input | 1 | Stop command for injected conversions |
| flag_clear | input | 1 | Software clear pulse for the sticky flag |
| win_level | output | 1 | Window status level for the timer trigger |
| win_flag | output | 1 | Sticky out-of-window flag |

## Verification
Two functions can fall in the same cycle:
- The hardware set and the software clear of the sticky flag can coincide. The bench provokes this directly by pulsing `flag_clear` in the same cycle as an out-of-window guarded strobe, and expects the flag to stay 1. A clear on its own then brings the flag to 0. Random stimulus also lands clear pulses on strobe cycles many times.
- The converter disable can coincide with a tripping result. The bench expects the level to be 0 and the flag to be 1.

A reference model in the bench computes the expected level and flag after every edge, and both outputs are compared on every cycle.

// File: rtl/awd_pkg.sv
package awd_pkg;

    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_INSIDE   = 2'd1,
        ST_OUTSIDE  = 2'd2
    } wd_state_e;

endpackage

// File: rtl/awd_guard_sel.sv
module awd_guard_sel #(
    parameter int N_CHAN = 19,
    parameter int CHAN_W = 5
) (
    input  logic [CHAN_W-1:0] conv_chan,
    input  logic [N_CHAN-1:0] guard_mask,
    input  logic              guard_all,
    output logic              guarded
);

    logic [N_CHAN-1:0] chan_hit;

    // One decoded compare per channel; channels at or beyond N_CHAN never match.
    for (genvar gi = 0; gi < N_CHAN; gi++) begin : g_chan
        always_comb chan_hit[gi] = guard_mask[gi] && (conv_chan == CHAN_W'(gi));
    end

    always_comb guarded = guard_all || (|chan_hit);

endmodule

// File: rtl/awd_window_cmp.sv
module awd_window_cmp #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] bound_lo,
    input  logic [DATA_W-1:0] bound_hi,
    output logic              outside
);

    logic below;
    logic above;

    // Bounds are inclusive: only strict excursions count as outside.
    always_comb begin
        below   = sample < bound_lo;
        above   = sample > bound_hi;
        outside = below || above;
    end

    always_comb begin
        if (outside) begin
            assert (sample != bound_lo && sample != bound_hi); // R3
        end
    end

endmodule

// File: rtl/awd_out_fsm.sv
module awd_out_fsm
    import awd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wd_enable,
    input  logic adc_disable,
    input  logic stop_regular,
    input  logic stop_injected,
    input  logic eval,
    input  logic outside,
    output logic level
);

    wd_state_e state;
    wd_state_e state_nx;

    always_comb begin
        state_nx = state;
        if (!wd_enable || adc_disable) begin
            state_nx = ST_DISARMED;                         // disarm
        end else begin
            unique case (state)
                ST_DISARMED: state_nx = (eval && outside) ? ST_OUTSIDE : ST_INSIDE; // arm
                ST_INSIDE:   if (eval && outside)  state_nx = ST_OUTSIDE;           // trip
                ST_OUTSIDE:  if (eval && !outside) state_nx = ST_INSIDE;            // recover
                default:     state_nx = ST_DISARMED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_DISARMED;
        else     state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_OUTSIDE: level = 1'b1;
            default:    level = 1'b0;
        endcase
    end

    AST_TRIP_RAISES: assert property (@(posedge clk) disable iff (rst)
        (wd_enable && !adc_disable && eval && outside) |=> level); // R2

    AST_RECOVER_DROPS: assert property (@(posedge clk) disable iff (rst)
        (wd_enable && !adc_disable && eval && !outside) |=> !level); // R4

    AST_NO_EVAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wd_enable && !adc_disable && !eval) |=> $stable(level)); // R4

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (!wd_enable) |=> !level); // R6

    AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (adc_disable) |=> !level); // R7

    AST_STOP_NEUTRAL: assert property (@(posedge clk) disable iff (rst)
        ((stop_regular || stop_injected) && wd_enable && !adc_disable && !eval)
        |=> $stable(level)); // R8

endmodule

// File: rtl/awd_flag.sv
module awd_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_hit,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_hit) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        set_hit |=> flag); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!set_hit && !clr) |=> $stable(flag)); // R9

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (!set_hit && clr) |=> !flag); // R9

endmodule

// File: rtl/adc_window_watch.sv
module adc_window_watch #(
    parameter int DATA_W = 12,
    parameter int N_CHAN = 19,
    parameter int CHAN_W = $clog2(N_CHAN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [CHAN_W-1:0] conv_chan,
    input  logic [N_CHAN-1:0] guard_mask,
    input  logic              guard_all,
    input  logic [DATA_W-1:0] thr_low,
    input  logic [DATA_W-1:0] thr_high,
    input  logic              wd_enable,
    input  logic              adc_disable,
    input  logic              stop_regular,
    input  logic              stop_injected,
    input  logic              flag_clear,
    output logic              win_level,
    output logic              win_flag
);

    logic guarded;
    logic outside;
    logic eval;
    logic set_hit;

    awd_guard_sel #(.N_CHAN(N_CHAN), .CHAN_W(CHAN_W)) u_guard (
        .conv_chan  (conv_chan),
        .guard_mask (guard_mask),
        .guard_all  (guard_all),
        .guarded    (guarded)
    );

    awd_window_cmp #(.DATA_W(DATA_W)) u_cmp (
        .sample   (conv_data),
        .bound_lo (thr_low),
        .bound_hi (thr_high),
        .outside  (outside)
    );

    always_comb begin
        eval    = conv_done && guarded;
        set_hit = eval && outside && wd_enable;
    end

    awd_out_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .wd_enable     (wd_enable),
        .adc_disable   (adc_disable),
        .stop_regular  (stop_regular),
        .stop_injected (stop_injected),
        .eval          (eval),
        .outside       (outside),
        .level         (win_level)
    );

    awd_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_hit (set_hit),
        .clr     (flag_clear),
        .flag    (win_flag)
    );

    AST_UNGUARDED_FLAG: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !guarded && !flag_clear) |=> $stable(win_flag)); // R5

endmodule

// File: tb/test_adc_window_watch.sv
module test_adc_window_watch;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 12;
    localparam int N_CHAN = 19;
    localparam int CHAN_W = $clog2(N_CHAN);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              conv_done = 1'b0;
    logic [DATA_W-1:0] conv_data = '0;
    logic [CHAN_W-1:0] conv_chan = '0;
    logic [N_CHAN-1:0] guard_mask = '0;
    logic              guard_all = 1'b0;
    logic [DATA_W-1:0] thr_low = '0;
    logic [DATA_W-1:0] thr_high = '1;
    logic              wd_enable = 1'b0;
    logic              adc_disable = 1'b0;
    logic              stop_regular = 1'b0;
    logic              stop_injected = 1'b0;
    logic              flag_clear = 1'b0;
    logic              win_level;
    logic              win_flag;

    int n_checks = 0;
    int n_fail = 0;
    logic exp_level = 1'b0;
    logic exp_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_window_watch #(.DATA_W(DATA_W), .N_CHAN(N_CHAN)) i_adc_window_watch (
        .clk(clk), .rst(rst), .conv_done(conv_done), .conv_data(conv_data),
        .conv_chan(conv_chan), .guard_mask(guard_mask), .guard_all(guard_all),
        .thr_low(thr_low), .thr_high(thr_high), .wd_enable(wd_enable),
        .adc_disable(adc_disable), .stop_regular(stop_regular),
        .stop_injected(stop_injected), .flag_clear(flag_clear),
        .win_level(win_level), .win_flag(win_flag)
    );

    function automatic logic is_guarded(logic [CHAN_W-1:0] ch, logic [N_CHAN-1:0] m, logic all);
        if (all) return 1'b1;
        if (int'(ch) < N_CHAN) return m[ch];
        return 1'b0;
    endfunction

    function automatic logic is_outside(logic [DATA_W-1:0] d, logic [DATA_W-1:0] lo, logic [DATA_W-1:0] hi);
        return (d < lo) || (d > hi);
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Advance one cycle: update the model at the edge, compare at the following falling edge.
    task automatic cyc(input string req);
        logic ev;
        logic out;
        @(posedge clk);
        ev  = conv_done && is_guarded(conv_chan, guard_mask, guard_all);
        out = is_outside(conv_data, thr_low, thr_high);
        if (rst) begin
            exp_level = 1'b0;
            exp_flag  = 1'b0;
        end else begin
            if (ev && out && wd_enable) exp_flag = 1'b1;
            else if (flag_clear)        exp_flag = 1'b0;
            if (!wd_enable || adc_disable) exp_level = 1'b0;
            else if (ev)                   exp_level = out;
        end
        @(negedge clk);
        check(req, "win_level", win_level, exp_level);
        check(req, "win_flag", win_flag, exp_flag);
    endtask

    task automatic idle();
        conv_done = 1'b0; flag_clear = 1'b0; adc_disable = 1'b0;
        stop_regular = 1'b0; stop_injected = 1'b0;
    endtask

    task automatic conv(input int d, input int ch, input string req);
        conv_done = 1'b1;
        conv_data = DATA_W'(d);
        conv_chan = CHAN_W'(ch);
        cyc(req);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        cyc("R1");
        cyc("R1");
        rst = 1'b0;
        wd_enable = 1'b1;
        guard_mask = '0;
        guard_mask[3] = 1'b1;
        thr_low = 12'd100;
        thr_high = 12'd200;
        cyc("R6");

        conv(100, 3, "R3");
        conv(200, 3, "R3");
        conv(99, 3, "R2");
        conv(150, 3, "R4");
        conv(201, 3, "R2");
        conv(4000, 3, "R4");
        cyc("R4");
        conv(0, 3, "R4");
        conv(150, 3, "R4");

        // Unguarded channels, including one past N_CHAN
        conv(5, 4, "R5");
        conv(5, 25, "R5");
        guard_all = 1'b1;
        conv(5, 25, "R5");
        guard_all = 1'b0;

        // Level falls and rises while flag stays set
        conv(150, 3, "R10");
        conv(300, 3, "R10");

        // Stops do nothing
        stop_regular = 1'b1; stop_injected = 1'b1;
        cyc("R8");
        stop_regular = 1'b1; conv(150, 3, "R8");
        stop_injected = 1'b1; conv(300, 3, "R8");

        // Disable forces level low, even with a tripping result, flag kept
        adc_disable = 1'b1;
        cyc("R7");
        adc_disable = 1'b1; flag_clear = 1'b1;
        conv(300, 3, "R7");
        cyc("R7");

        // Set and clear together: set wins; clear alone clears
        flag_clear = 1'b1;
        conv(10, 3, "R9");
        flag_clear = 1'b1;
        cyc("R9");
        cyc("R9");

        // Watchdog off: no evaluation
        wd_enable = 1'b0;
        conv(10, 3, "R6");
        cyc("R6");
        wd_enable = 1'b1;
        cyc("R6");

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            if (i % 64 == 0) begin
                thr_low    = DATA_W'($urandom_range(0, 2000));
                thr_high   = thr_low + DATA_W'($urandom_range(0, 1500));
                guard_mask = N_CHAN'($urandom);
                guard_all  = ($urandom_range(0, 3) == 0);
            end
            conv_done     = ($urandom_range(0, 1) == 1);
            conv_chan     = CHAN_W'($urandom_range(0, 31));
            case ($urandom_range(0, 3))
                0: conv_data = thr_low - DATA_W'($urandom_range(0, 1));
                1: conv_data = thr_high + DATA_W'($urandom_range(0, 1));
                default: conv_data = DATA_W'($urandom);
            endcase
            wd_enable     = ($urandom_range(0, 9) != 0);
            adc_disable   = ($urandom_range(0, 19) == 0);
            flag_clear    = ($urandom_range(0, 7) == 0);
            stop_regular  = ($urandom_range(0, 5) == 0);
            stop_injected = ($urandom_range(0, 5) == 0);
            rst           = ($urandom_range(0, 499) == 0);
            cyc("R2");
        end
        idle();
        rst = 1'b1;
        cyc("R1");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule